// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave-side front end of a byte-wide serial EEPROM. It watches chip select, serial clock, serial data in and a hold input. It assembles an 8-bit instruction from the incoming bits and then any address and data bytes. For the two read instructions it streams bytes out on the serial data output. Six instructions are recognised: set and clear a write-enable latch, read and write a small status word, and read and write the memory array. The array is held in a synchronous single-port RAM that can map onto block RAM.

The engine runs entirely on a fast system clock. The four serial inputs pass through a short synchronizer, and the clock is oversampled to find its rising and falling edges. SCK may idle low (mode 0) or high (mode 3). In both modes bits are captured on the rising edge and the output is updated on the falling edge. A transaction is framed by chip select. Raising it at any point abandons the transaction, and the next low period starts again with an opcode. The output enable stands in for a tri-state pad.

The array depth is set by `ADDR_W`. A full 128 KiB part uses 17. The default of 11 (2 KiB) keeps elaboration light. Reads and writes always take three address bytes. Bits above `ADDR_W` are discarded, and the address counter wraps at the top of the array.

Top module: `spi_eeprom_engine`

## Requirements
- R1: In both SCK polarities (idle low and idle high), SI is captured on SCK rising edges and SO changes only after SCK falling edges. Every opcode, address and data byte travels most significant bit first.
- R2: Bits 7..4 of an opcode must be 0 and bit 3 is ignored. Bits 2..0 select the instruction: 110 set enable, 100 clear enable, 101 read status, 001 write status, 011 read array, 010 write array.
- R3: An opcode with a nonzero upper nibble, or with low bits 000 or 111, is ignored until chip select rises. SO stays undriven, no array byte changes and the enable latch keeps its value.
- R4: The write-enable latch is 0 after reset. It is set by the set-enable opcode and cleared by the clear-enable opcode. It is also cleared when chip select rises after a write-array or write-status instruction that changed something.
- R5: Write-array takes three address bytes, then data bytes. Each byte is stored at the current address, which then increments and wraps from the top of the array to 0. With the latch clear, the whole instruction is ignored.
- R6: Read-array takes three address bytes and uses only the low `ADDR_W` bits. From the next SCK falling edge it streams bytes from consecutive addresses, wrapping from the top of the array to 0, for as long as chip select stays low.
- R7: Read-status returns a byte with bit 7 as the protect-enable flag, bits 3..2 as the two block-protect bits, bit 1 as the enable latch, and bits 6..4 and bit 0 as 0. The byte repeats while chip select stays low.
- R8: Write-status with the latch set copies data bits 7, 3 and 2 into the protect-enable flag and the two block-protect bits. With the latch clear, the status is unchanged.
- R9: While HOLD is low, SCK edges are ignored and SO is undriven. After HOLD returns high, the transfer continues where it stopped.
- R10: SO is driven only while a read instruction is streaming data with chip select low. A chip-select rise mid-instruction abandons it with no effect.
- R11: After reset, SO is 0, SO is undriven and the status byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO |

## Verification
A bad bit counter or state register shows up within one byte at the ports. A misread opcode leaves the enable bit wrong in the next status read. A mis-shifted address returns another location's byte on the first read-back, and a bad prefetch shows up on the second streamed byte. Faults in the latch and the protect bits are exposed by status reads taken right after each set, clear, write and abandoned transaction. Hold and framing faults appear as SO being driven while it should be released, within a few system clocks of the HOLD or chip-select change.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADR, ST_RDAT, ST_WDAT, ST_STAT, ST_WSTAT, ST_IDLE
  } eep_state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_WEN, OP_WDIS, OP_RSTAT, OP_WSTAT, OP_READ, OP_WRITE
  } eep_op_t;

  function automatic eep_op_t op_decode(input logic [7:0] b);
    eep_op_t r;
    r = OP_NONE;
    if (b[7:4] == 4'h0) begin
      case (b[2:0])
        3'b110:  r = OP_WEN;
        3'b100:  r = OP_WDIS;
        3'b101:  r = OP_RSTAT;
        3'b001:  r = OP_WSTAT;
        3'b011:  r = OP_READ;
        3'b010:  r = OP_WRITE;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_eep_frontend.sv
module spi_eep_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_q,
  output logic si_q,
  output logic hold_q
);
  localparam int PW = 4 * SYNC_STAGES;
  localparam logic [3:0] IDLE_V = 4'b0101;

  logic [PW-1:0] pipe;
  logic [3:0]    raw, synced;
  logic          sck_d;

  assign raw = {sck, cs_n, si, hold_n};

  if (SYNC_STAGES == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) pipe <= IDLE_V;
      else     pipe <= raw;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) pipe <= {SYNC_STAGES{IDLE_V}};
      else     pipe <= {pipe[PW-5:0], raw};
    end
  end

  assign synced = pipe[PW-1 -: 4];

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= synced[3];
  end

  assign sck_rise = synced[3] & ~sck_d;
  assign sck_fall = ~synced[3] & sck_d;
  assign cs_q     = synced[2];
  assign si_q     = synced[1];
  assign hold_q   = synced[0];
endmodule

// File: rtl/spi_eep_ram.sv
module spi_eep_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wd;
      rd <= mem[addr];
    end
  end
endmodule

// File: rtl/spi_eep_txser.sv
module spi_eep_txser #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          hold_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          shift,
  output logic          so,
  output logic          so_oe,
  output logic          last
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] tx;
  logic [CW-1:0] cnt;
  logic          drv;

  assign last = shift && (cnt == CW'(DW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx    <= '0;
      cnt   <= '0;
      so    <= 1'b0;
      drv   <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      if (clear) begin
        cnt <= '0;
        drv <= 1'b0;
      end else begin
        if (load) tx <= ld_data;
        if (shift) begin
          so  <= tx[DW-1];
          tx  <= {tx[DW-2:0], 1'b0};
          cnt <= cnt + 1'b1;
          drv <= 1'b1;
        end
      end
      so_oe <= ~clear & hold_n & (drv | shift);
    end
  end
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
  import spi_eep_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int NADR = 3;

  logic sck_rise, sck_fall, cs_q, si_q, hold_q;
  logic act_rise, act_fall, byte_done, shift, last;
  logic [6:0] rx;
  logic [2:0] bcnt;
  logic [7:0] rx_byte, status, ld_data, ram_rd, ram_wd;
  logic [1:0] abyte;
  logic [1:0] bp_q;
  logic [ADDR_W-1:0] addr, addr_sh, ram_addr;
  logic rd_mode, wel_q, wpen_q, wrote, pend_ram, pend_stat;
  logic ram_en, ram_we;
  eep_state_t st;

  spi_eep_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_fe (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_q(cs_q), .si_q(si_q),
    .hold_q(hold_q)
  );

  assign act_rise  = sck_rise & ~cs_q & hold_q;
  assign act_fall  = sck_fall & ~cs_q & hold_q;
  assign rx_byte   = {rx, si_q};
  assign byte_done = act_rise && (bcnt == 3'd7);
  assign addr_sh   = {addr[ADDR_W-9:0], rx_byte};
  assign shift     = act_fall && (st == ST_RDAT || st == ST_STAT);
  assign status    = {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
  assign ld_data   = pend_stat ? status : ram_rd;
  assign ram_wd    = rx_byte;

  // RAM port steering: address read at end of address phase, write per
  // data byte, prefetch of the next byte while the last bit goes out.
  always_comb begin
    ram_en   = 1'b0;
    ram_we   = 1'b0;
    ram_addr = addr;
    if (byte_done && st == ST_ADR && abyte == 2'(NADR - 1) && rd_mode) begin
      ram_en   = 1'b1;
      ram_addr = addr_sh;
    end
    if (byte_done && st == ST_WDAT) begin
      ram_en = 1'b1;
      ram_we = 1'b1;
    end
    if (last && st == ST_RDAT) begin
      ram_en   = 1'b1;
      ram_addr = addr + 1'b1;
    end
  end

  spi_eep_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr), .wd(ram_wd),
    .rd(ram_rd)
  );

  spi_eep_txser #(.DW(8)) u_tx (
    .clk(clk), .rst(rst), .clear(cs_q), .hold_n(hold_q),
    .load(pend_ram | pend_stat), .ld_data(ld_data), .shift(shift),
    .so(so), .so_oe(so_oe), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_OPC;
      rx        <= '0;
      bcnt      <= '0;
      abyte     <= '0;
      addr      <= '0;
      rd_mode   <= 1'b0;
      wel_q     <= 1'b0;
      wpen_q    <= 1'b0;
      bp_q      <= '0;
      wrote     <= 1'b0;
      pend_ram  <= 1'b0;
      pend_stat <= 1'b0;
    end else begin
      pend_ram  <= 1'b0;
      pend_stat <= 1'b0;
      if (cs_q) begin
        st    <= ST_OPC;
        bcnt  <= '0;
        abyte <= '0;
        if (wrote) wel_q <= 1'b0;
        wrote <= 1'b0;
      end else begin
        if (act_rise) begin
          rx   <= rx_byte[6:0];
          bcnt <= bcnt + 1'b1;
        end
        if (byte_done) begin
          case (st)
            ST_OPC: begin
              case (op_decode(rx_byte))
                OP_WEN:   begin wel_q <= 1'b1; st <= ST_IDLE; end
                OP_WDIS:  begin wel_q <= 1'b0; st <= ST_IDLE; end
                OP_RSTAT: begin st <= ST_STAT; pend_stat <= 1'b1; end
                OP_WSTAT: st <= wel_q ? ST_WSTAT : ST_IDLE;
                OP_READ:  begin st <= ST_ADR; rd_mode <= 1'b1; end
                OP_WRITE: begin
                  st      <= wel_q ? ST_ADR : ST_IDLE;
                  rd_mode <= 1'b0;
                end
                default:  st <= ST_IDLE;
              endcase
            end
            ST_ADR: begin
              addr  <= addr_sh;
              abyte <= abyte + 1'b1;
              if (abyte == 2'(NADR - 1)) begin
                st       <= rd_mode ? ST_RDAT : ST_WDAT;
                pend_ram <= rd_mode;
              end
            end
            ST_WDAT: begin
              addr  <= addr + 1'b1;
              wrote <= 1'b1;
            end
            ST_WSTAT: begin
              wpen_q <= rx_byte[7];
              bp_q   <= rx_byte[3:2];
              wrote  <= 1'b1;
              st     <= ST_IDLE;
            end
            default: ;
          endcase
        end
        if (last) begin
          if (st == ST_RDAT) begin
            addr     <= addr + 1'b1;
            pend_ram <= 1'b1;
          end
          if (st == ST_STAT) pend_stat <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_eep_chk.sv
module spi_eep_chk (
  input logic clk,
  input logic rst,
  input logic cs_q,
  input logic hold_q,
  input logic sck_fall,
  input logic so,
  input logic so_oe,
  input logic ram_we,
  input logic wel_q
);
  // R10
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !so_oe);

  // R9
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_q |=> !so_oe);

  // R1
  so_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(so) |-> $past(sck_fall));

  // R5
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (wel_q && !cs_q));

  // R4
  enable_set_framed_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wel_q) |-> !$past(cs_q));
endmodule

bind spi_eeprom_engine spi_eep_chk u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .hold_q(hold_q), .sck_fall(sck_fall),
  .so(so), .so_oe(so_oe), .ram_we(ram_we), .wel_q(wel_q)
);

// File: tb/sim_spi_eeprom_engine.sv
`timescale 1ns/1ps
module sim_spi_eeprom_engine;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;

  int  errs = 0, checks = 0;
  bit  done = 1'b0, mode3 = 1'b0;
  bit  m_wel = 1'b0, m_wpen = 1'b0;
  logic [1:0] m_bp = 2'b00;
  logic [7:0] model [DEPTH];
  bit  vld [DEPTH];
  logic hold_oe;

  spi_eeprom_engine #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_status();
    return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  function automatic logic [7:0] opc(input logic [7:0] base);
    return base | (($urandom & 1) != 0 ? 8'h08 : 8'h00);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    @(negedge clk); sck = mode3;
    ticks(HALF); cs_n = 1'b0; ticks(HALF);
  endtask

  task automatic cs_end();
    @(negedge clk); sck = mode3;
    ticks(HALF); cs_n = 1'b1; ticks(8);
  endtask

  // one byte, MSB first; hb selects a bit index at which HOLD is pulsed
  task automatic xbyte(input logic [7:0] b, input int hb, output logic [7:0] r,
                       output logic ao, output logic an);
    ao = 1'b1; an = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; si = b[i];
      ticks(HALF);
      if (hb == i) begin
        hold_n = 1'b0; ticks(4);
        hold_oe = so_oe;
        si = ~b[i]; sck = 1'b1; ticks(HALF);
        sck = 1'b0; ticks(HALF);
        si = b[i]; hold_n = 1'b1; ticks(4);
      end
      r[i] = so;
      ao = ao & so_oe;
      an = an | so_oe;
      sck = 1'b1; ticks(HALF);
    end
  endtask

  task automatic send_addr(input int a, output logic an);
    logic [23:0] full;
    logic [7:0] r;
    logic ao, n1;
    full = ($urandom & 24'hFF_FFFF & ~24'(DEPTH - 1)) | 24'(a);
    an = 1'b0;
    xbyte(full[23:16], -1, r, ao, n1); an |= n1;
    xbyte(full[15:8],  -1, r, ao, n1); an |= n1;
    xbyte(full[7:0],   -1, r, ao, n1); an |= n1;
  endtask

  task automatic simple_op(input logic [7:0] op);
    logic [7:0] r; logic ao, an;
    cs_begin(); xbyte(opc(op), -1, r, ao, an); cs_end();
  endtask

  task automatic wren(); simple_op(8'h06); m_wel = 1'b1; endtask
  task automatic wrdi(); simple_op(8'h04); m_wel = 1'b0; endtask

  task automatic t_rdsr(input string req);
    logic [7:0] r; logic ao, an;
    cs_begin();
    xbyte(opc(8'h05), -1, r, ao, an);
    chk(!an, req, an, 0);
    for (int k = 0; k < 2; k++) begin
      xbyte(8'h00, -1, r, ao, an);
      chk(r == exp_status(), req, r, exp_status());
      chk(ao, req, ao, 1);
    end
    cs_end();
    chk(!so_oe, "R10", so_oe, 0);
  endtask

  task automatic t_wrsr(input logic [7:0] v);
    logic [7:0] r; logic ao, an;
    cs_begin();
    xbyte(opc(8'h01), -1, r, ao, an);
    xbyte(v, -1, r, ao, an);
    cs_end();
    if (m_wel) begin
      m_wpen = v[7]; m_bp = v[3:2]; m_wel = 1'b0;
    end
  endtask

  task automatic t_write(input int a, input int n);
    logic [7:0] r, d; logic ao, an;
    cs_begin();
    xbyte(opc(8'h02), -1, r, ao, an);
    send_addr(a, an);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      xbyte(d, -1, r, ao, an);
      chk(!an, "R10", an, 0);
      if (m_wel) begin
        model[(a + k) % DEPTH] = d;
        vld[(a + k) % DEPTH] = 1'b1;
      end
    end
    cs_end();
    if (m_wel && n > 0) m_wel = 1'b0;
  endtask

  task automatic t_read(input int a, input int n, input int hbyte,
                        input string req);
    logic [7:0] r; logic ao, an;
    int idx;
    cs_begin();
    xbyte(opc(8'h03), -1, r, ao, an);
    send_addr(a, an);
    chk(!an, "R10", an, 0);
    for (int k = 0; k < n; k++) begin
      idx = (a + k) % DEPTH;
      hold_oe = 1'b1;
      xbyte(8'($urandom), (k == hbyte) ? 3 : -1, r, ao, an);
      if (k == hbyte) chk(hold_oe == 1'b0, "R9", hold_oe, 0);
      if (vld[idx]) chk(r == model[idx], req, r, model[idx]);
      chk(ao, req, ao, 1);
    end
    cs_end();
  endtask

  initial begin
    logic [7:0] r; logic ao, an;
    void'($urandom(32'h5EED_0421));
    for (int i = 0; i < DEPTH; i++) vld[i] = 1'b0;
    ticks(5);
    rst = 1'b0;
    ticks(3);
    chk(so == 1'b0, "R11", so, 0);
    chk(so_oe == 1'b0, "R11", so_oe, 0);

    // power-up status, idle-low clock
    t_rdsr("R11");
    // write without enable is ignored
    wren(); t_write(16, 2);
    t_write(16, 2);                 // m_wel now 0: no model update
    t_read(16, 2, -1, "R5");
    // enable latch set / clear with bit 3 either way
    wren(); t_rdsr("R4");
    wrdi(); t_rdsr("R2");
    // status write with and without enable
    t_wrsr(8'hFF); t_rdsr("R8");
    wren(); t_wrsr(8'hFF); t_rdsr("R8");
    wren(); t_wrsr(8'h73); t_rdsr("R7");
    // invalid opcodes leave latch and array alone
    wren();
    cs_begin();
    xbyte(8'h12, -1, r, ao, an); send_addr(16, an);
    xbyte(8'h5A, -1, r, ao, an);
    chk(!an, "R3", an, 0);
    cs_end();
    simple_op(8'h07); simple_op(8'h00); simple_op(8'hA3);
    t_rdsr("R3");
    t_read(16, 1, -1, "R3");
    // abandoned write keeps latch set
    cs_begin();
    xbyte(opc(8'h02), -1, r, ao, an);
    xbyte(8'h00, -1, r, ao, an);
    cs_end();
    t_rdsr("R10");
    wrdi();
    // wrap at the top of the array, both directions
    wren(); t_write(DEPTH - 2, 4);
    t_read(DEPTH - 2, 4, -1, "R6");
    wren(); t_write(DEPTH - 1, 1);
    t_read(DEPTH - 1, 3, -1, "R5");
    // idle-high clock
    mode3 = 1'b1;
    t_rdsr("R1");
    wren(); t_write(100, 3);
    t_read(100, 3, -1, "R1");
    // hold in the middle of a streamed byte
    t_read(100, 3, 1, "R9");
    mode3 = 1'b0;
    t_read(100, 3, 2, "R9");
    // random mix
    for (int it = 0; it < 24; it++) begin
      int a, n;
      mode3 = ($urandom & 1) != 0;
      a = $urandom % 64;
      n = 1 + ($urandom % 4);
      if (($urandom & 1) != 0) begin
        if (($urandom % 4) != 0) wren();
        t_write(a, n);
      end else begin
        t_read(a, n, -1, "R6");
      end
      if ((it % 6) == 5) t_rdsr("R7");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule